// File: doc/BRIEF.md
# Gated-Operand ALU with Post-Shifter

This block is the arithmetic core of a narrow microcoded datapath. One operand comes from a holding register and the other from a shared bus. Six independent control bits choose the result. Two bits pick one of four operations. Two bits let each operand through or force it to zero. One bit inverts the first operand. One bit adds a carry into the sum. With this scheme, sixteen useful results come out of a single small function unit: pass, complement, add, add-plus-one, increment, decrement, subtract, negate, AND, OR and the constants 0, 1 and -1.

A shift stage follows the function unit and has its own two controls. One control gives a logical left shift by a byte. The other gives an arithmetic right shift by one bit. The negative and zero flags are taken from the unshifted function result. A microsequencer can therefore branch on the computed value while the shifted value goes to the result bus. The block is purely combinational.

Top module: `alu_shift_top`

## Requirements
- R1: When `gate_a_i` is 0 the first operand is treated as zero; when `gate_b_i` is 0 the second operand is treated as zero.
- R2: When `invert_a_i` is 1 the gated first operand is bitwise complemented before the function unit.
- R3: `func_sel_i` = 2'b00 yields the bitwise AND of the prepared operands.
- R4: `func_sel_i` = 2'b01 yields the bitwise OR of the prepared operands.
- R5: `func_sel_i` = 2'b10 yields the complement of the gated second operand; the first operand has no effect.
- R6: `func_sel_i` = 2'b11 yields the modulo-2^32 sum of the prepared operands plus `carry_in_i`.
- R7: `neg_o` equals bit 31 of the unshifted function result.
- R8: `zero_o` is 1 exactly when the unshifted function result is all zeros, whatever the shift controls are.
- R9: With `shl_i`=1 and `sra_i`=0, `result_o` is the function result shifted left by 8 bits, with zeros filled in from the bottom.
- R10: With `sra_i`=1 and `shl_i`=0, `result_o` is the function result shifted right by 1 bit, with bit 31 replicated.
- R11: With both shift controls 0, `result_o` equals the function result.
- R12: `carry_in_i` has no effect on the result unless `func_sel_i` is 2'b11.
- R13: All sixteen listed useful control combinations give their named result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand, from the holding register |
| b_i | input | 32 | Second operand, from the shared bus |
| func_sel_i | input | 2 | Operation: 00 AND, 01 OR, 10 NOT second, 11 ADD |
| gate_a_i | input | 1 | Passes the first operand; 0 forces it to zero |
| gate_b_i | input | 1 | Passes the second operand; 0 forces it to zero |
| invert_a_i | input | 1 | Complements the gated first operand |
| carry_in_i | input | 1 | Carry into the adder |
| shl_i | input | 1 | Logical left shift by 8 |
| sra_i | input | 1 | Arithmetic right shift by 1 |
| result_o | output | 32 | Shifted result |
| neg_o | output | 1 | Sign bit of the unshifted result |
| zero_o | output | 1 | Unshifted result is zero |

## Verification
The hardest case to reach is one where the flags and the shifted output disagree. Examples are a nonzero result whose high byte is lost by the left shift, and a zero flag raised while a shift is active. Random operands almost never produce a zero sum. For that reason the stimulus builds exact cancellations directly. Subtracting B from itself with both shift modes gives a zero result. Values with only the top byte set, shifted left, give an all-zero output while the zero flag stays low. Sign-boundary operands cover the arithmetic right shift.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } fn_e;
endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             gate_a_i,
  input  logic             gate_b_i,
  input  logic             invert_a_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o
);
  logic [WIDTH-1:0] a_gated;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign a_gated[i] = a_i[i] & gate_a_i;
    assign a_o[i]     = a_gated[i] ^ invert_a_i;
    assign b_o[i]     = b_i[i] & gate_b_i;
  end
endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  fn_e              fn_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] y_o,
  output logic             neg_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] sum;

  assign sum = a_i + b_i + {{(WIDTH-1){1'b0}}, carry_i};

  always_comb begin
    unique case (fn_i)
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_NOTB: y_o = ~b_i;
      default: y_o = sum;
    endcase
  end

  assign neg_o  = y_o[WIDTH-1];
  assign zero_o = ~|y_o;
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned SHL_AMT = 8
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic             shl_i,
  input  logic             sra_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] shl_val;
  logic [WIDTH-1:0] sra_val;

  if (SHL_AMT >= WIDTH) begin : g_shl_all
    assign shl_val = '0;
  end else begin : g_shl_part
    assign shl_val = {d_i[WIDTH-1-SHL_AMT:0], {SHL_AMT{1'b0}}};
  end

  assign sra_val = {d_i[WIDTH-1], d_i[WIDTH-1:1]};

  always_comb begin
    if (shl_i)      q_o = shl_val;
    else if (sra_i) q_o = sra_val;
    else            q_o = d_i;
  end

  always_comb begin
    if (shl_i && !sra_i && SHL_AMT < WIDTH) begin
      AST_SHL_ZERO_FILL: assert (q_o[0] == 1'b0) else $error("shl fill"); // R9
    end
  end
endmodule

// File: rtl/alu_shift_top.sv
module alu_shift_top
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned SHL_AMT = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       func_sel_i,
  input  logic             gate_a_i,
  input  logic             gate_b_i,
  input  logic             invert_a_i,
  input  logic             carry_in_i,
  input  logic             shl_i,
  input  logic             sra_i,
  output logic [WIDTH-1:0] result_o,
  output logic             neg_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] a_prep, b_prep, fu_y;

  alu_operand_prep #(.WIDTH(WIDTH)) i_prep (
    .a_i, .b_i, .gate_a_i, .gate_b_i, .invert_a_i,
    .a_o(a_prep), .b_o(b_prep)
  );

  alu_func_unit #(.WIDTH(WIDTH)) i_fu (
    .a_i(a_prep), .b_i(b_prep), .fn_i(fn_e'(func_sel_i)), .carry_i(carry_in_i),
    .y_o(fu_y), .neg_o(neg_o), .zero_o(zero_o)
  );

  alu_shifter #(.WIDTH(WIDTH), .SHL_AMT(SHL_AMT)) i_shift (
    .d_i(fu_y), .shl_i, .sra_i, .q_o(result_o)
  );

  always_comb begin
    if (zero_o) begin
      AST_ZERO_SHIFTED_ZERO: assert (result_o == '0) else $error("zero flag"); // R8
    end
    if (sra_i && !shl_i) begin
      AST_SRA_SIGN_KEPT: assert (result_o[WIDTH-1] == neg_o) else $error("sra sign"); // R10
    end
    if (!sra_i && !shl_i) begin
      AST_PASS_SIGN: assert (result_o[WIDTH-1] == neg_o) else $error("pass sign"); // R7
      AST_PASS_ZERO: assert ((result_o == '0) == zero_o) else $error("pass zero"); // R11
    end
    if (!gate_a_i && !gate_b_i && !invert_a_i && func_sel_i == 2'b00) begin
      AST_GATED_AND_ZERO: assert (zero_o) else $error("gating"); // R1
    end
  end
endmodule

// File: tb/test_alu_shift_top.sv
module test_alu_shift_top;
  localparam int W = 32;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a, b, res;
  logic [1:0] fs;
  logic ga, gb, ia, ci, shl, sra, neg, zro;
  int checks = 0, fails = 0;
  bit done = 0;

  alu_shift_top i_alu_shift_top (
    .a_i(a), .b_i(b), .func_sel_i(fs), .gate_a_i(ga), .gate_b_i(gb),
    .invert_a_i(ia), .carry_in_i(ci), .shl_i(shl), .sra_i(sra),
    .result_o(res), .neg_o(neg), .zero_o(zro)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [1:0] f,
                                         logic ea, logic eb, logic inv, logic c);
    longint unsigned xa, yb;
    xa = ea ? x : 0;
    if (inv) xa = xa ^ 64'hFFFF_FFFF;
    yb = eb ? y : 0;
    case (f)
      2'd0: return W'(xa & yb);
      2'd1: return W'(xa | yb);
      2'd2: return W'(~yb);
      default: return W'(xa + yb + c);
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] exp_alu);
    logic [W-1:0] exp_res;
    if (shl) exp_res = exp_alu << 8;
    else if (sra) exp_res = W'($signed(exp_alu) >>> 1);
    else exp_res = exp_alu;
    checks++;
    if (res !== exp_res || neg !== exp_alu[W-1] || zro !== (exp_alu == 0)) begin
      fails++;
      $display("FAIL %s: res=%h n=%b z=%b expected res=%h n=%b z=%b", req, res, neg, zro,
               exp_res, exp_alu[W-1], exp_alu == 0);
    end
  endtask

  task automatic drive(logic [1:0] f, logic ea, logic eb, logic inv, logic c,
                       logic sl, logic sr, logic [W-1:0] x, logic [W-1:0] y);
    @(posedge clk); #2;
    fs = f; ga = ea; gb = eb; ia = inv; ci = c; shl = sl; sra = sr; a = x; b = y;
    #2;
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL watchdog: expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] x, y;
    x = 32'h1234_5678; y = 32'h0F0F_00F1;
    // idle inputs: all zero
    drive(2'b00, 0, 0, 0, 0, 0, 0, '0, '0); check("R1 idle", '0);
    // R13 table of useful combinations, R11 no shift
    drive(2'b01, 1, 0, 0, 0, 0, 0, x, y); check("R13 A", x);
    drive(2'b01, 0, 1, 0, 0, 0, 0, x, y); check("R13 B", y);
    drive(2'b01, 1, 0, 1, 0, 0, 0, x, y); check("R13 notA R2", ~x);
    drive(2'b10, 1, 1, 0, 0, 0, 0, x, y); check("R13 notB R5", ~y);
    drive(2'b11, 1, 1, 0, 0, 0, 0, x, y); check("R13 A+B R6", x + y);
    drive(2'b11, 1, 1, 0, 1, 0, 0, x, y); check("R13 A+B+1", x + y + 1);
    drive(2'b11, 1, 0, 0, 1, 0, 0, x, y); check("R13 A+1", x + 1);
    drive(2'b11, 0, 1, 0, 1, 0, 0, x, y); check("R13 B+1", y + 1);
    drive(2'b11, 1, 1, 1, 1, 0, 0, x, y); check("R13 B-A", y - x);
    drive(2'b11, 0, 1, 1, 0, 0, 0, x, y); check("R13 B-1", y - 1);
    drive(2'b11, 1, 0, 1, 1, 0, 0, x, y); check("R13 -A", -x);
    drive(2'b00, 1, 1, 0, 0, 0, 0, x, y); check("R13 AND R3", x & y);
    drive(2'b01, 1, 1, 0, 0, 0, 0, x, y); check("R13 OR R4", x | y);
    drive(2'b01, 0, 0, 0, 0, 0, 0, x, y); check("R13 zero R1", 0);
    drive(2'b11, 0, 0, 0, 1, 0, 0, x, y); check("R13 one", 1);
    drive(2'b11, 0, 0, 1, 0, 0, 0, x, y); check("R13 minus1", '1);
    // R5: A has no effect in NOT-B mode
    drive(2'b10, 1, 1, 1, 0, 0, 0, 32'hFFFF_FFFF, y); check("R5 A ignored", ~y);
    // R12: carry ignored in logic modes
    drive(2'b00, 1, 1, 0, 1, 0, 0, x, y); check("R12 and carry", x & y);
    drive(2'b01, 1, 1, 0, 1, 0, 0, x, y); check("R12 or carry", x | y);
    drive(2'b10, 0, 1, 0, 1, 0, 0, x, y); check("R12 notb carry", ~y);
    // R6 wrap
    drive(2'b11, 1, 1, 0, 1, 0, 0, 32'hFFFF_FFFF, 32'h0); check("R6 wrap", 0);
    // R8 zero with shifts, R9 high byte lost, R10 sign
    drive(2'b11, 1, 1, 1, 1, 1, 0, y, y); check("R8 zero shl", 0);
    drive(2'b11, 1, 1, 1, 1, 0, 1, y, y); check("R8 zero sra", 0);
    drive(2'b01, 1, 0, 0, 0, 1, 0, 32'hAB00_0000, y); check("R9 byte lost", 32'hAB00_0000);
    drive(2'b01, 1, 0, 0, 0, 1, 0, x, y); check("R9 shl", x);
    drive(2'b01, 1, 0, 0, 0, 0, 1, 32'h8000_0001, y); check("R10 sra neg", 32'h8000_0001);
    drive(2'b01, 1, 0, 0, 0, 0, 1, 32'h7FFF_FFFF, y); check("R10 sra pos", 32'h7FFF_FFFF);
    drive(2'b11, 0, 0, 1, 0, 0, 1, x, y); check("R10 sra -1 R7", '1);
    // random sweep against the model
    for (int i = 0; i < 400; i++) begin
      logic [2:0] sh;
      logic [5:0] ctl;
      x = $urandom; y = $urandom; ctl = 6'($urandom); sh = 3'($urandom_range(0, 2));
      drive(ctl[5:4], ctl[3], ctl[2], ctl[1], ctl[0], sh == 1, sh == 2, x, y);
      check("R6 R7 R8 random", model(x, y, ctl[5:4], ctl[3], ctl[2], ctl[1], ctl[0]));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule